// File: doc/BRIEF.md
# Upper-Half Bit-Field Extract Unit

This unit sits in the execute stage of a 64-bit pipeline. It takes a 32-bit instruction word and a 64-bit source operand. When the word encodes an extract of a bit field whose lowest bit lies at position 32 or above, the unit shifts that field down to bit 0 and clears every bit above it. It returns the result together with the destination and source register indices, and a write-enable for the register file.

Two faults are detected in hardware. An input `ext_enable` tells the unit whether the extension is present. If it is not, a matching word raises a reserved-instruction flag and produces no result. If the encoded field would run past bit 63, the unit raises an out-of-range flag, forces the result to zero and holds the write-enable low.

Words that do not match the encoding pass through with no effect. All outputs come from a single register stage.

Top module: `ubx_unit`

## Requirements
- R1: A word is accepted only when `in_valid` is high, bits 31..26 equal 011111 and bits 5..0 equal 000010. Any other word, or an idle cycle, produces `out_valid`=0 with all other outputs zero.
- R2: For an accepted word, `out_dst` carries bits 20..16 and `out_src` carries bits 25..21.
- R3: Bits 15..11 hold the field width minus one. Bits 10..6 hold the field's lowest source bit minus 32. The lowest source bit is therefore that value plus 32.
- R4: For a legal accepted word with the extension present, `out_result` bits width-1..0 equal source bits lsb+width-1..lsb, all higher result bits are zero, and `out_wen` is 1. This includes the boundary cases of width 32 at position 32 and width 1 at position 63.
- R5: When lsb + width exceeds 64 and the extension is present, `out_range_err`=1, `out_result`=0 and `out_wen`=0.
- R6: When `ext_enable`=0, an accepted word gives `out_resv`=1, `out_range_err`=0, `out_result`=0 and `out_wen`=0, whatever the field geometry.
- R7: Outputs for an input appear exactly one clock after it. An accepted word sets exactly one of `out_wen`, `out_resv` and `out_range_err`.
- R8: A synchronous, active-high `rst` clears every output at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction word and operand are valid |
| insn | input | 32 | Instruction word |
| src_data | input | 64 | Source operand |
| ext_enable | input | 1 | 1 when the extension is implemented |
| out_valid | output | 1 | An accepted word was processed last cycle |
| out_result | output | 64 | Extracted field, right-justified and zero-extended |
| out_dst | output | 5 | Destination register index |
| out_src | output | 5 | Source register index |
| out_wen | output | 1 | Register write-enable |
| out_resv | output | 1 | Reserved-instruction flag |
| out_range_err | output | 1 | Illegal field geometry flag |

## Verification
The assertions assume that `rst` is held for at least one clock before checking starts. They also assume that `insn` and `ext_enable` are stable across each rising edge. The bench meets both conditions by driving every input on the falling edge and by asserting reset before any instruction.

The bench covers every width from 1 to 32 and every offset from 0 to 31. It does this by drawing both encoded fields uniformly, so that legal and over-range geometries both occur often. It also toggles `ext_enable` and mixes in near-miss opcodes and idle cycles.

// File: rtl/ubx_pkg.sv
package ubx_pkg;
  localparam int unsigned INSN_W = 32;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned IDX_W  = 5;
  localparam int unsigned FLD_W  = 5;
  localparam int unsigned HALF   = DATA_W / 2;
  localparam int unsigned OPC_W  = 6;
  localparam logic [OPC_W-1:0] OPC_MAJOR = 6'b011111;
  localparam logic [OPC_W-1:0] OPC_MINOR = 6'b000010;

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] src;
    logic [IDX_W-1:0] dst;
    logic [FLD_W-1:0] top;  // width - 1
    logic [FLD_W-1:0] off;  // lowest source bit - HALF
  } ubx_dec_t;

  // field runs past the last source bit when off + top + 1 > HALF
  function automatic logic over_top(input logic [FLD_W-1:0] top,
                                    input logic [FLD_W-1:0] off);
    logic [FLD_W:0] sum;
    sum = {1'b0, off} + {1'b0, top};
    return sum > FLD_W'(HALF - 1);
  endfunction

  function automatic logic [DATA_W-1:0] field_mask(input logic [FLD_W-1:0] top);
    return {DATA_W{1'b1}} >> (DATA_W - 1 - int'(top));
  endfunction

  function automatic logic [DATA_W-1:0] pull_field(input logic [DATA_W-1:0] src,
                                                   input logic [FLD_W-1:0] top,
                                                   input logic [FLD_W-1:0] off);
    return (src >> (HALF + int'(off))) & field_mask(top);
  endfunction
endpackage

// File: rtl/ubx_decode.sv
module ubx_decode
  import ubx_pkg::*;
(
  input  logic              in_valid,
  input  logic [INSN_W-1:0] insn,
  output ubx_dec_t          dec
);
  localparam int unsigned MAJ_LSB = INSN_W - OPC_W;
  localparam int unsigned SRC_LSB = MAJ_LSB - IDX_W;
  localparam int unsigned DST_LSB = SRC_LSB - IDX_W;
  localparam int unsigned TOP_LSB = DST_LSB - FLD_W;
  localparam int unsigned OFF_LSB = TOP_LSB - FLD_W;

  logic major_ok, minor_ok;

  always_comb begin
    major_ok = insn[INSN_W-1 -: OPC_W] == OPC_MAJOR;
    minor_ok = insn[OPC_W-1:0] == OPC_MINOR;
    dec.hit  = in_valid && major_ok && minor_ok;
    dec.src  = insn[SRC_LSB +: IDX_W];
    dec.dst  = insn[DST_LSB +: IDX_W];
    dec.top  = insn[TOP_LSB +: FLD_W];
    dec.off  = insn[OFF_LSB +: FLD_W];
  end
endmodule

// File: rtl/ubx_extract.sv
module ubx_extract
  import ubx_pkg::*;
(
  input  logic [DATA_W-1:0] src_data,
  input  logic [FLD_W-1:0]  top,
  input  logic [FLD_W-1:0]  off,
  output logic [DATA_W-1:0] field,
  output logic              over
);
  always_comb begin
    field = pull_field(src_data, top, off);
    over  = over_top(top, off);
  end
endmodule

// File: rtl/ubx_unit.sv
module ubx_unit
  import ubx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [INSN_W-1:0] insn,
  input  logic [DATA_W-1:0] src_data,
  input  logic              ext_enable,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result,
  output logic [IDX_W-1:0]  out_dst,
  output logic [IDX_W-1:0]  out_src,
  output logic              out_wen,
  output logic              out_resv,
  output logic              out_range_err
);
  ubx_dec_t          dec;
  logic              dec_hit;
  logic              over_top_w;
  logic [DATA_W-1:0] field_w;
  logic              take_resv, take_range, take_write;

  ubx_decode u_dec (
    .in_valid (in_valid),
    .insn     (insn),
    .dec      (dec)
  );

  ubx_extract u_ext (
    .src_data (src_data),
    .top      (dec.top),
    .off      (dec.off),
    .field    (field_w),
    .over     (over_top_w)
  );

  always_comb begin
    dec_hit    = dec.hit;
    take_resv  = dec_hit && !ext_enable;
    take_range = dec_hit && ext_enable && over_top_w;
    take_write = dec_hit && ext_enable && !over_top_w;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_result    <= '0;
      out_dst       <= '0;
      out_src       <= '0;
      out_wen       <= 1'b0;
      out_resv      <= 1'b0;
      out_range_err <= 1'b0;
    end else begin
      out_valid     <= dec_hit;
      out_result    <= take_write ? field_w : '0;
      out_dst       <= dec_hit ? dec.dst : '0;
      out_src       <= dec_hit ? dec.src : '0;
      out_wen       <= take_write;
      out_resv      <= take_resv;
      out_range_err <= take_range;
    end
  end
endmodule

// File: rtl/ubx_checker.sv
module ubx_checker
  import ubx_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              ext_enable,
  input logic [IDX_W-1:0]  dst_in,
  input logic [IDX_W-1:0]  src_in,
  input logic              hit_w,
  input logic              over_w,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_result,
  input logic [IDX_W-1:0]  out_dst,
  input logic [IDX_W-1:0]  out_src,
  input logic              out_wen,
  input logic              out_resv,
  input logic              out_range_err
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_result == '0 && out_dst == '0 && out_src == '0 &&
                    !out_wen && !out_resv && !out_range_err)); // R1

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    hit_w |=> out_valid); // R7

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !hit_w |=> !out_valid); // R1

  AST_INDEX_CARRY: assert property (@(posedge clk) disable iff (rst)
    hit_w |=> (out_dst == $past(dst_in) && out_src == $past(src_in))); // R2

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $countones({out_wen, out_resv, out_range_err}) == 1); // R7

  AST_RESV_WINS: assert property (@(posedge clk) disable iff (rst)
    (hit_w && !ext_enable) |=> (out_resv && !out_range_err && !out_wen)); // R6

  AST_RANGE_FLAG: assert property (@(posedge clk) disable iff (rst)
    (hit_w && ext_enable && over_w) |=> (out_range_err && !out_wen)); // R5

  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (out_resv || out_range_err) |-> out_result == '0); // R5

  AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    out_wen |-> out_result[DATA_W-1:HALF] == '0); // R4

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !out_wen && !out_resv && !out_range_err)); // R8
endmodule

bind ubx_unit ubx_checker u_chk (
  .clk           (clk),
  .rst           (rst),
  .ext_enable    (ext_enable),
  .dst_in        (insn[20:16]),
  .src_in        (insn[25:21]),
  .hit_w         (dec_hit),
  .over_w        (over_top_w),
  .out_valid     (out_valid),
  .out_result    (out_result),
  .out_dst       (out_dst),
  .out_src       (out_src),
  .out_wen       (out_wen),
  .out_resv      (out_resv),
  .out_range_err (out_range_err)
);

// File: tb/ubx_unit_test.sv
module ubx_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] insn = '0;
  logic [63:0] src_data = '0;
  logic        ext_enable = 1'b1;
  logic        out_valid;
  logic [63:0] out_result;
  logic [4:0]  out_dst, out_src;
  logic        out_wen, out_resv, out_range_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    bit          v;
    logic [63:0] res;
    logic [4:0]  dst, src;
    bit          wen, resv, rng;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ubx_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
    .src_data(src_data), .ext_enable(ext_enable),
    .out_valid(out_valid), .out_result(out_result), .out_dst(out_dst),
    .out_src(out_src), .out_wen(out_wen), .out_resv(out_resv),
    .out_range_err(out_range_err)
  );

  function automatic logic [31:0] mk(input int major, input int rs, input int rt,
                                     input int width, input int pos, input int minor);
    logic [31:0] w;
    w[31:26] = 6'(major);
    w[25:21] = 5'(rs);
    w[20:16] = 5'(rt);
    w[15:11] = 5'(width - 1);  // R3: width minus one
    w[10:6]  = 5'(pos - 32);   // R3: position minus 32
    w[5:0]   = 6'(minor);
    return w;
  endfunction

  function automatic exp_t model(input bit r, input bit iv, input logic [31:0] w,
                                 input logic [63:0] s, input bit en, input string tag);
    exp_t e;
    int pos, width;
    e = '{v:0, res:'0, dst:'0, src:'0, wen:0, resv:0, rng:0, tag:tag};
    if (r) return e;
    if (!(iv && w[31:26] == 6'h1f && w[5:0] == 6'h02)) return e;
    e.v = 1; e.dst = w[20:16]; e.src = w[25:21];
    pos = int'(w[10:6]) + 32;
    width = int'(w[15:11]) + 1;
    if (!en) e.resv = 1;
    else if (pos + width > 64) e.rng = 1;
    else begin
      e.wen = 1;
      for (int i = 0; i < width; i++) e.res[i] = s[pos + i];
    end
    return e;
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act,
                     input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  task automatic compare_pending();
    exp_t e;
    if (exp_q.size() == 0) return;
    e = exp_q.pop_front();
    chk(e.tag, "valid",  64'(out_valid), 64'(e.v));
    chk(e.tag, "result", out_result, e.res);
    chk(e.tag, "dst",    64'(out_dst), 64'(e.dst));
    chk(e.tag, "src",    64'(out_src), 64'(e.src));
    chk(e.tag, "wen",    64'(out_wen), 64'(e.wen));
    chk(e.tag, "resv",   64'(out_resv), 64'(e.resv));
    chk(e.tag, "range",  64'(out_range_err), 64'(e.rng));
  endtask

  task automatic step(input bit r, input bit iv, input logic [31:0] w,
                      input logic [63:0] s, input bit en, input string tag);
    @(negedge clk);
    compare_pending();
    rst = r; in_valid = iv; insn = w; src_data = s; ext_enable = en;
    exp_q.push_back(model(r, iv, w, s, en, tag));
  endtask

  localparam logic [63:0] PAT = 64'hF0E1_D2C3_B4A5_9687;

  initial begin
    step(1, 1, mk(31, 3, 4, 8, 40, 2), PAT, 1, "R8");
    step(1, 0, '0, '0, 1, "R8");
    step(0, 1, mk(31, 7, 9, 32, 32, 2), PAT, 1, "R4");   // full upper half
    step(0, 1, mk(31, 1, 2, 1, 63, 2), PAT, 1, "R4");    // top bit only
    step(0, 1, mk(31, 5, 6, 8, 40, 2), PAT, 1, "R3");
    step(0, 1, mk(31, 2, 30, 24, 40, 2), PAT, 1, "R4");  // ends at bit 63
    step(0, 1, mk(31, 2, 30, 25, 40, 2), PAT, 1, "R5");  // one past
    step(0, 1, mk(31, 8, 8, 2, 63, 2), PAT, 1, "R5");
    step(0, 1, mk(31, 8, 8, 4, 33, 2), PAT, 0, "R6");
    step(0, 1, mk(31, 8, 8, 32, 63, 2), PAT, 0, "R6");   // bad geometry, reserved wins
    step(0, 1, mk(30, 8, 8, 4, 33, 2), PAT, 1, "R1");    // wrong major
    step(0, 1, mk(31, 8, 8, 4, 33, 3), PAT, 1, "R1");    // wrong minor
    step(0, 0, mk(31, 8, 8, 4, 33, 2), PAT, 1, "R1");    // not valid
    step(0, 1, mk(31, 11, 22, 16, 48, 2), ~PAT, 1, "R2");
    step(1, 1, mk(31, 11, 22, 16, 48, 2), ~PAT, 1, "R8"); // reset beats input
    step(0, 1, mk(31, 12, 13, 5, 50, 2), PAT, 1, "R7");
    step(0, 0, '0, PAT, 1, "R7");
    for (int n = 0; n < 1500; n++) begin
      logic [31:0] w;
      logic [63:0] s;
      bit en, iv;
      string tag;
      w = $urandom();
      s = {$urandom(), $urandom()};
      iv = ($urandom_range(0, 7) != 0);
      en = ($urandom_range(0, 5) != 0);
      if ($urandom_range(0, 3) != 0) begin
        w[31:26] = 6'h1f; w[5:0] = 6'h02;
      end
      tag = "R4";
      if (!(iv && w[31:26] == 6'h1f && w[5:0] == 6'h02)) tag = "R1";
      else if (!en) tag = "R6";
      else if (int'(w[10:6]) + int'(w[15:11]) > 31) tag = "R5";
      step(0, iv, w, s, en, tag);
    end
    @(negedge clk);
    compare_pending();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R7 watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule